// File: doc/BRIEF.md
# UART In-Band Flow-Control Engine

This block sits between a UART's character receiver and its receive FIFO, and beside its transmitter. It handles in-band pause/resume flow control. A 4-bit mode input selects two things. The upper half chooses which pause/resume characters the block emits toward the remote end when asked. The lower half chooses how incoming characters are compared against four programmable character registers: two resume characters and two pause characters. Matching characters stop or restart the local transmitter and are kept out of the FIFO. All other characters pass through to the FIFO write port.

In one combination the receive compare needs a two-character sequence instead of a single character. For that case the block holds the first character of a possible sequence. If the sequence breaks, it releases that character to the FIFO as ordinary data. A separate special-character detector compares every received byte with the second pause register. It sets a sticky status flag, which is also used as an interrupt source. A second sticky flag records every accepted pause.

Top module: `uart_swflow_engine`

## Requirements
- R1: After reset, tx_enable is 1 and fifo_wr, fc_tx_valid, flow_irq and spc_irq are 0.
- R2: fc_mode[3:2] selects emitted characters, applied when ask_pause (pause characters, wins over ask_resume) or ask_resume is seen while fc_tx_valid is 0. 00 emits nothing, 10 emits the first character, 01 emits the second, and 11 emits the first and then the second. fc_tx_data stays stable while fc_tx_valid=1 and fc_tx_ready=0. Requests made while fc_tx_valid is 1 are dropped.
- R3: fc_mode[1:0]=10 compares with the first pause/resume characters and 01 with the second ones. A matching byte pauses or resumes and is not written to the FIFO. A byte equal to both a pause and a resume character counts as a pause.
- R4: With fc_mode[1:0]=11 and fc_mode[3:2] equal to 10 or 01, either pause character pauses and either resume character resumes.
- R5: With fc_mode[1:0]=11 and fc_mode[3:2] equal to 00 or 11, a pause needs pause1 followed by pause2, and a resume needs resume1 followed by resume2. Both bytes of a completed pair are kept out of the FIFO.
- R6: In the pair mode, if the byte after a held first character does not complete the pair, the held character is written to the FIFO one cycle after that byte is taken. The byte itself is then re-evaluated in the following cycle, so it can start a new pair.
- R7: An accepted pause clears tx_enable on the first clock edge at which tx_idle is 1, from the edge that takes the byte onward. An accepted resume sets tx_enable and cancels a waiting pause.
- R8: With spc_en=1, a received byte equal to the pause2 register (bit 0 against bit 0) sets the special flag. Under fc_mode[1:0]=10 such a byte is still written to the FIFO.
- R9: With spc_en=1 and fc_mode[1:0]=01, a received pause2 byte is not written to the FIFO and sets both the pause flag and the special flag.
- R10: Both flags are sticky and are cleared by irq_ack. A set in the same cycle wins over irq_ack. flow_irq is the pause flag gated by flow_irq_en, and spc_irq is the special flag gated by spc_irq_en.
- R11: With fc_mode[1:0]=00 every received byte is written unchanged to the FIFO one cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_mode | input | 4 | [3:2] emit selection, [1:0] receive compare selection |
| spc_en | input | 1 | Special-character detect enable |
| xon1_chr | input | DW | First resume character |
| xon2_chr | input | DW | Second resume character |
| xoff1_chr | input | DW | First pause character |
| xoff2_chr | input | DW | Second pause character, also the special character |
| rx_valid | input | 1 | Received byte strobe (at least one idle cycle between strobes) |
| rx_data | input | DW | Received byte |
| tx_idle | input | 1 | Transmitter between characters |
| ask_pause | input | 1 | Request to emit pause characters |
| ask_resume | input | 1 | Request to emit resume characters |
| fc_tx_ready | input | 1 | Transmitter accepts the offered flow character |
| irq_ack | input | 1 | Clears both sticky flags |
| flow_irq_en | input | 1 | Pause interrupt enable |
| spc_irq_en | input | 1 | Special-character interrupt enable |
| fifo_wr | output | 1 | Write strobe to receive FIFO |
| fifo_data | output | DW | Byte written to receive FIFO |
| tx_enable | output | 1 | Local transmitter may start characters |
| fc_tx_valid | output | 1 | A flow character is offered |
| fc_tx_data | output | DW | Offered flow character |
| flow_irq | output | 1 | Gated pause flag |
| spc_irq | output | 1 | Gated special flag |

## Verification
Two functions can collide in one cycle. The first is the special-character detector setting its flag on a byte that the flow compare consumes as a pause. The second is the replay of a broken pair landing in the cycle after the held character is released. The bench provokes the first by programming pause2 as the special character under compare modes 01 and 10. It provokes the second by feeding resume1 then pause1 then pause2 in pair mode. A behavioural model tracks the FIFO writes, both flags and tx_enable every cycle. Any divergence in either case is charged to the requirement under test.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
   localparam logic [1:0] FC_NONE = 2'b00;
   localparam logic [1:0] FC_SET2 = 2'b01;
   localparam logic [1:0] FC_SET1 = 2'b10;
   localparam logic [1:0] FC_BOTH = 2'b11;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'b00,
      SEQ_OFF1 = 2'b01,
      SEQ_ON1  = 2'b10
   } seq_st_e;

   function automatic logic single_sel(input logic [1:0] sel);
      return (sel == FC_SET1) || (sel == FC_SET2);
   endfunction
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
   import swfc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    rx_sel,
   input  logic [1:0]    tx_sel,
   input  logic [DW-1:0] on1,
   input  logic [DW-1:0] on2,
   input  logic [DW-1:0] off1,
   input  logic [DW-1:0] off2,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          pause_o,
   output logic          resume_o,
   output logic          fifo_wr,
   output logic [DW-1:0] fifo_data
);
   seq_st_e       seq_st, st_n;
   logic [DW-1:0] held, held_n;
   logic          rep_v, rep_v_n;
   logic [DW-1:0] rep_b, rep_b_n;
   logic          wr_n;
   logic [DW-1:0] wdat_n;
   logic          byte_v, seq_mode;
   logic [DW-1:0] byte_w;
   logic          h_on1, h_on2, h_off1, h_off2;

   assign byte_v   = in_valid | rep_v;
   assign byte_w   = in_valid ? in_data : rep_b;
   assign seq_mode = (rx_sel == FC_BOTH) && !single_sel(tx_sel);
   assign h_on1    = (byte_w == on1);
   assign h_on2    = (byte_w == on2);
   assign h_off1   = (byte_w == off1);
   assign h_off2   = (byte_w == off2);

   always_comb begin
      pause_o  = 1'b0;
      resume_o = 1'b0;
      wr_n     = 1'b0;
      wdat_n   = byte_w;
      st_n     = seq_mode ? seq_st : SEQ_IDLE;
      held_n   = held;
      rep_v_n  = 1'b0;
      rep_b_n  = rep_b;
      if (byte_v) begin
         case (rx_sel)
            FC_NONE: wr_n = 1'b1;
            FC_SET1: begin
               if (h_off1)     pause_o  = 1'b1;
               else if (h_on1) resume_o = 1'b1;
               else            wr_n     = 1'b1;
            end
            FC_SET2: begin
               if (h_off2)     pause_o  = 1'b1;
               else if (h_on2) resume_o = 1'b1;
               else            wr_n     = 1'b1;
            end
            default: begin
               if (!seq_mode) begin
                  if (h_off1 || h_off2)     pause_o  = 1'b1;
                  else if (h_on1 || h_on2)  resume_o = 1'b1;
                  else                      wr_n     = 1'b1;
               end else begin
                  case (seq_st)
                     SEQ_OFF1: begin
                        st_n = SEQ_IDLE;
                        if (h_off2) pause_o = 1'b1;
                        else begin
                           wr_n    = 1'b1;
                           wdat_n  = held;
                           rep_v_n = 1'b1;
                           rep_b_n = byte_w;
                        end
                     end
                     SEQ_ON1: begin
                        st_n = SEQ_IDLE;
                        if (h_on2) resume_o = 1'b1;
                        else begin
                           wr_n    = 1'b1;
                           wdat_n  = held;
                           rep_v_n = 1'b1;
                           rep_b_n = byte_w;
                        end
                     end
                     default: begin
                        if (h_off1) begin
                           st_n   = SEQ_OFF1;
                           held_n = byte_w;
                        end else if (h_on1) begin
                           st_n   = SEQ_ON1;
                           held_n = byte_w;
                        end else wr_n = 1'b1;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_st    <= SEQ_IDLE;
         held      <= '0;
         rep_v     <= 1'b0;
         rep_b     <= '0;
         fifo_wr   <= 1'b0;
         fifo_data <= '0;
      end else begin
         seq_st    <= st_n;
         held      <= held_n;
         rep_v     <= rep_v_n;
         rep_b     <= rep_b_n;
         fifo_wr   <= wr_n;
         fifo_data <= wdat_n;
      end
   end

   // R3: a consumed flow character never reaches the FIFO
   a_r3_consumed_not_written: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_v && (pause_o || resume_o)) |=> !fifo_wr);

   // R11: pass-through when compare is off
   a_r11_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_v && rx_sel == FC_NONE) |=> (fifo_wr && fifo_data == $past(byte_w)));

   // R6: broken pair releases the held byte
   a_r6_release_held: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_v && seq_mode && seq_st == SEQ_OFF1 && !h_off2) |=> (fifo_wr && fifo_data == $past(held)));

   // R5: a pair cannot be pending outside pair mode
   a_r5_no_pend_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_mode |=> (seq_st == SEQ_IDLE));
endmodule

// File: rtl/swfc_tx_gate.sv
module swfc_tx_gate #(
   parameter bit WAIT_IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pause_i,
   input  logic resume_i,
   input  logic tx_idle,
   output logic tx_enable
);
   generate
      if (WAIT_IDLE) begin : g_wait
         logic stop_pend;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_enable <= 1'b1;
               stop_pend <= 1'b0;
            end else if (resume_i) begin
               tx_enable <= 1'b1;
               stop_pend <= 1'b0;
            end else if (pause_i || stop_pend) begin
               if (tx_idle) begin
                  tx_enable <= 1'b0;
                  stop_pend <= 1'b0;
               end else begin
                  stop_pend <= 1'b1;
               end
            end
         end
      end else begin : g_now
         logic unused_idle;
         assign unused_idle = tx_idle;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        tx_enable <= 1'b1;
            else if (resume_i) tx_enable <= 1'b1;
            else if (pause_i)  tx_enable <= 1'b0;
         end
      end
   endgenerate

   // R7: resume always re-enables
   a_r7_resume_enables: assert property (@(posedge clk) disable iff (!rst_n)
      resume_i |=> tx_enable);

   // R7: pause while idle stops at once
   a_r7_pause_idle_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_i && tx_idle && !resume_i) |=> !tx_enable);
endmodule

// File: rtl/swfc_flow_sender.sv
module swfc_flow_sender
   import swfc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    tx_sel,
   input  logic [DW-1:0] on1,
   input  logic [DW-1:0] on2,
   input  logic [DW-1:0] off1,
   input  logic [DW-1:0] off2,
   input  logic          ask_pause,
   input  logic          ask_resume,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] data
);
   logic          sec_v;
   logic [DW-1:0] sec_b;
   logic [DW-1:0] c1, c2;

   assign c1 = ask_pause ? off1 : on1;
   assign c2 = ask_pause ? off2 : on2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         sec_v <= 1'b0;
         sec_b <= '0;
      end else if (valid) begin
         if (ready) begin
            if (sec_v) begin
               data  <= sec_b;
               sec_v <= 1'b0;
            end else begin
               valid <= 1'b0;
            end
         end
      end else if ((ask_pause || ask_resume) && tx_sel != FC_NONE) begin
         valid <= 1'b1;
         data  <= (tx_sel == FC_SET2) ? c2 : c1;
         sec_v <= (tx_sel == FC_BOTH);
         sec_b <= c2;
      end
   end

   // R2: offered character held until taken
   a_r2_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(data)));

   // R2: nothing emitted when emission is off
   a_r2_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && tx_sel == FC_NONE) |=> !valid);
endmodule

// File: rtl/uart_swflow_engine.sv
module uart_swflow_engine
   import swfc_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit WAIT_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    fc_mode,
   input  logic          spc_en,
   input  logic [DW-1:0] xon1_chr,
   input  logic [DW-1:0] xon2_chr,
   input  logic [DW-1:0] xoff1_chr,
   input  logic [DW-1:0] xoff2_chr,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          tx_idle,
   input  logic          ask_pause,
   input  logic          ask_resume,
   input  logic          fc_tx_ready,
   input  logic          irq_ack,
   input  logic          flow_irq_en,
   input  logic          spc_irq_en,
   output logic          fifo_wr,
   output logic [DW-1:0] fifo_data,
   output logic          tx_enable,
   output logic          fc_tx_valid,
   output logic [DW-1:0] fc_tx_data,
   output logic          flow_irq,
   output logic          spc_irq
);
   localparam logic [1:0] TX_SEL_LSB = 2'd2;

   initial begin : p_param_chk
      assert (DW >= 5 && DW <= 16) else $error("DW out of range");
   end

   logic [1:0] rx_sel, tx_sel;
   logic       pause_w, resume_w;
   logic       flow_flag, spc_flag, spc_hit;

   assign rx_sel  = fc_mode[1:0];
   assign tx_sel  = fc_mode[TX_SEL_LSB +: 2];
   assign spc_hit = rx_valid && spc_en && (rx_data == xoff2_chr);

   swfc_rx_match #(.DW(DW)) u_match (
      .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .tx_sel(tx_sel),
      .on1(xon1_chr), .on2(xon2_chr), .off1(xoff1_chr), .off2(xoff2_chr),
      .in_valid(rx_valid), .in_data(rx_data),
      .pause_o(pause_w), .resume_o(resume_w),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data)
   );

   swfc_tx_gate #(.WAIT_IDLE(WAIT_IDLE)) u_gate (
      .clk(clk), .rst_n(rst_n), .pause_i(pause_w), .resume_i(resume_w),
      .tx_idle(tx_idle), .tx_enable(tx_enable)
   );

   swfc_flow_sender #(.DW(DW)) u_send (
      .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
      .on1(xon1_chr), .on2(xon2_chr), .off1(xoff1_chr), .off2(xoff2_chr),
      .ask_pause(ask_pause), .ask_resume(ask_resume), .ready(fc_tx_ready),
      .valid(fc_tx_valid), .data(fc_tx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flow_flag <= 1'b0;
         spc_flag  <= 1'b0;
      end else begin
         flow_flag <= pause_w || (flow_flag && !irq_ack);
         spc_flag  <= spc_hit || (spc_flag && !irq_ack);
      end
   end

   assign flow_irq = flow_flag && flow_irq_en;
   assign spc_irq  = spc_flag && spc_irq_en;

   // R8: special match sets the flag
   a_r8_spc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      spc_hit |=> spc_flag);

   // R10: acknowledge clears when nothing new arrives
   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !pause_w && !spc_hit) |=> (!flow_flag && !spc_flag));

   // R10: flags are sticky without acknowledge
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_flag && !irq_ack) |=> flow_flag);
endmodule

// File: tb/uart_swflow_engine_test.sv
module uart_swflow_engine_test;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    fc_mode = 4'b0000;
   logic          spc_en = 1'b0;
   logic [DW-1:0] xon1_chr = 8'h11, xon2_chr = 8'h51, xoff1_chr = 8'h13, xoff2_chr = 8'h53;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          tx_idle = 1'b1, ask_pause = 1'b0, ask_resume = 1'b0, fc_tx_ready = 1'b1;
   logic          irq_ack = 1'b0, flow_irq_en = 1'b1, spc_irq_en = 1'b1;
   logic          fifo_wr, tx_enable, fc_tx_valid, flow_irq, spc_irq;
   logic [DW-1:0] fifo_data, fc_tx_data;

   uart_swflow_engine #(.DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .spc_en(spc_en),
      .xon1_chr(xon1_chr), .xon2_chr(xon2_chr), .xoff1_chr(xoff1_chr), .xoff2_chr(xoff2_chr),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_idle(tx_idle),
      .ask_pause(ask_pause), .ask_resume(ask_resume), .fc_tx_ready(fc_tx_ready),
      .irq_ack(irq_ack), .flow_irq_en(flow_irq_en), .spc_irq_en(spc_irq_en),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .tx_enable(tx_enable),
      .fc_tx_valid(fc_tx_valid), .fc_tx_data(fc_tx_data),
      .flow_irq(flow_irq), .spc_irq(spc_irq)
   );

   always #10 clk = ~clk;

   int    vectors = 0, miscompares = 0, cycles = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic          m_wr, m_txen, m_stop, m_ff, m_sf, m_rv;
   logic [DW-1:0] m_dat, m_rb, m_held;
   int            m_pend;
   logic [DW-1:0] m_q[$];

   always @(posedge clk) begin
      logic [DW-1:0] b;
      logic          have, pz, rs, seqm, single_tx;
      logic [1:0]    rxm, txm;
      if (!rst_n) begin
         m_wr = 0; m_dat = '0; m_txen = 1; m_stop = 0; m_ff = 0; m_sf = 0;
         m_rv = 0; m_rb = '0; m_held = '0; m_pend = 0; m_q.delete();
      end else begin
         rxm = fc_mode[1:0]; txm = fc_mode[3:2];
         single_tx = (txm == 2'b10) || (txm == 2'b01);
         seqm = (rxm == 2'b11) && !single_tx;
         pz = 0; rs = 0; m_wr = 0; have = 0; b = '0;
         if (!seqm) m_pend = 0;
         if (irq_ack) begin m_ff = 0; m_sf = 0; end
         if (rx_valid) begin
            if (spc_en && rx_data == xoff2_chr) m_sf = 1;
            b = rx_data; have = 1; m_rv = 0;
         end else if (m_rv) begin
            b = m_rb; have = 1; m_rv = 0;
         end
         if (have) begin
            if (rxm == 2'b00) begin m_wr = 1; m_dat = b; end
            else if (rxm == 2'b10) begin
               if (b == xoff1_chr) pz = 1; else if (b == xon1_chr) rs = 1;
               else begin m_wr = 1; m_dat = b; end
            end else if (rxm == 2'b01) begin
               if (b == xoff2_chr) pz = 1; else if (b == xon2_chr) rs = 1;
               else begin m_wr = 1; m_dat = b; end
            end else if (!seqm) begin
               if (b == xoff1_chr || b == xoff2_chr) pz = 1;
               else if (b == xon1_chr || b == xon2_chr) rs = 1;
               else begin m_wr = 1; m_dat = b; end
            end else if (m_pend == 0) begin
               if (b == xoff1_chr) begin m_pend = 1; m_held = b; end
               else if (b == xon1_chr) begin m_pend = 2; m_held = b; end
               else begin m_wr = 1; m_dat = b; end
            end else begin
               if (m_pend == 1 && b == xoff2_chr) pz = 1;
               else if (m_pend == 2 && b == xon2_chr) rs = 1;
               else begin m_wr = 1; m_dat = m_held; m_rv = 1; m_rb = b; end
               m_pend = 0;
            end
         end
         if (pz) m_ff = 1;
         if (rs) begin m_txen = 1; m_stop = 0; end
         else if (pz || m_stop) begin
            if (tx_idle) begin m_txen = 0; m_stop = 0; end else m_stop = 1;
         end
         if (m_q.size() > 0) begin
            if (fc_tx_ready) void'(m_q.pop_front());
         end else if ((ask_pause || ask_resume) && txm != 2'b00) begin
            if (txm == 2'b10 || txm == 2'b11) m_q.push_back(ask_pause ? xoff1_chr : xon1_chr);
            if (txm == 2'b01 || txm == 2'b11) m_q.push_back(ask_pause ? xoff2_chr : xon2_chr);
         end
      end
   end

   task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("fifo_wr", {7'b0, fifo_wr}, {7'b0, m_wr});
         if (m_wr) chk("fifo_data", fifo_data, m_dat);
         chk("tx_enable", {7'b0, tx_enable}, {7'b0, m_txen});
         chk("flow_irq", {7'b0, flow_irq}, {7'b0, m_ff & flow_irq_en});
         chk("spc_irq", {7'b0, spc_irq}, {7'b0, m_sf & spc_irq_en});
         chk("fc_tx_valid", {7'b0, fc_tx_valid}, {7'b0, m_q.size() > 0});
         if (m_q.size() > 0) chk("fc_tx_data", fc_tx_data, m_q[0]);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 100000) begin
         miscompares++;
         $display("FAIL watchdog expired at cycle %0d, expected end of run", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
   endtask

   task automatic rx(input logic [DW-1:0] b);
      step(1); rx_valid = 1; rx_data = b;
      step(1); rx_valid = 0;
      step(2);
   endtask

   initial begin
      step(3);
      rst_n = 1;
      cur_req = "R1"; step(3);

      cur_req = "R11"; fc_mode = 4'b0000;
      rx(8'h41); rx(xoff1_chr); rx(xon2_chr); rx(8'h00);

      cur_req = "R3"; fc_mode = 4'b0010; tx_idle = 0;
      rx(8'h42); rx(xoff2_chr); rx(xoff1_chr);
      cur_req = "R7"; step(3); tx_idle = 1; step(2); tx_idle = 0;
      rx(xon1_chr); rx(xoff1_chr); rx(xon1_chr); tx_idle = 1;
      cur_req = "R3"; fc_mode = 4'b0001;
      rx(xoff2_chr); rx(xon1_chr); rx(xon2_chr);
      xon2_chr = xoff2_chr; rx(xoff2_chr); rx(xon2_chr); xon2_chr = 8'h51;

      cur_req = "R10"; flow_irq_en = 0; step(2); irq_ack = 1; step(1); irq_ack = 0; flow_irq_en = 1; step(2);

      cur_req = "R9"; spc_en = 1; fc_mode = 4'b0001;
      rx(xoff2_chr); rx(xon2_chr);
      cur_req = "R10"; spc_irq_en = 0; step(2); spc_irq_en = 1;
      step(1); irq_ack = 1; rx_valid = 1; rx_data = xoff2_chr; step(1); irq_ack = 0; rx_valid = 0; step(2);
      irq_ack = 1; step(1); irq_ack = 0; step(2);

      cur_req = "R8"; fc_mode = 4'b0010;
      rx(xoff2_chr); rx(8'h53 ^ 8'h01); irq_ack = 1; step(1); irq_ack = 0;
      fc_mode = 4'b0000; rx(xoff2_chr); spc_en = 0; rx(xoff2_chr); rx(xon1_chr);

      cur_req = "R4"; fc_mode = 4'b1011;
      rx(xoff2_chr); rx(xon1_chr); rx(xoff1_chr); rx(xon2_chr); rx(8'h7e);
      fc_mode = 4'b0111; rx(xoff1_chr); rx(xon2_chr);

      cur_req = "R5"; fc_mode = 4'b0011;
      rx(xoff1_chr); rx(xoff2_chr); rx(xon1_chr); rx(xon2_chr);
      fc_mode = 4'b1111; rx(xoff1_chr); rx(xoff2_chr); rx(xon1_chr); rx(xon2_chr);
      cur_req = "R6";
      rx(xoff1_chr); rx(8'h61); rx(xon1_chr); rx(xoff1_chr); rx(xoff2_chr);
      rx(xon1_chr); rx(xon1_chr); rx(xon2_chr); rx(xoff1_chr); rx(xon2_chr);

      cur_req = "R2"; fc_tx_ready = 0;
      for (int m = 0; m < 4; m++) begin
         fc_mode = {m[1:0], 2'b00};
         step(1); ask_pause = 1; ask_resume = (m == 2); step(1); ask_pause = 0; ask_resume = 0;
         step(3); ask_resume = 1; step(1); ask_resume = 0;
         fc_tx_ready = 1; step(1); fc_tx_ready = 0; step(2); fc_tx_ready = 1; step(3);
         ask_resume = 1; step(1); ask_resume = 0; step(4); fc_tx_ready = 0;
      end
      fc_tx_ready = 1; step(4);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule